// File: doc/BRIEF.md
# Oscillator Jitter Entropy Word Collector

This block gathers raw entropy from two banks of free-running oscillators and packs it into 32-bit words for a processor to fetch. Every oscillator line is first brought into the system clock domain. Each bank is then folded into a single parity bit, and that bit is latched once per sample interval. The default interval is 4096 system clocks, which is roughly 4.4 kHz at an 18 MHz clock.

One output bit is formed from two consecutive sample instants of both banks, so the bit mixes entropy across space and across time. The output bit rate is half the sample rate. Output bits enter a word register, which keeps absorbing bits whether or not anyone reads it, so it always holds the most recent 32 bits. A ready flag reports that a whole fresh word has arrived since the last read, and a one-cycle read strobe clears that flag.

Top module: `entropy_word_collector`

## Requirements
- R1: While `rst_ni` is low at a rising clock edge, the block clears all of its state: the interval counter, the synchronizers, the latched samples, the pairing state, the fresh-bit count, `word_o` (0) and `ready_o` (0). After reset is released, the first sample is taken at the clock edge that completes `SAMPLE_INTERVAL` cycles.
- R2: Each oscillator input passes through a two-stage synchronizer. Its value is taken only at the interval edge, so an input change that starts and ends between two interval edges has no effect on `word_o`.
- R3: At each sample edge, each bank is reduced to the XOR of all of its synchronized bits. An even count of ones gives 0 and an odd count gives 1.
- R4: One conditioned bit is produced for every two sample edges. It equals the XOR of the two reduced bits of bank A and the two reduced bits of bank B from that pair of edges. Pairing restarts at reset.
- R5: Each conditioned bit enters `word_o` at bit 0 while the older bits move up by one place. The bit that was at bit 31 is discarded.
- R6: After reset, `ready_o` rises on the cycle that the 32nd conditioned bit enters the word. It stays high while further bits arrive and no read occurs.
- R7: Shifting never pauses for an unread word. `word_o` always equals the last 32 conditioned bits, or the bits so far padded with zeros.
- R8: When `rd_strobe_i` is high at a clock edge, `ready_o` is low after that edge. It rises again only when 32 conditioned bits have entered after the read.
- R9: When a read strobe and a conditioned bit land on the same edge, the read wins and `ready_o` stays low. That bit counts as the first of the next 32, so `ready_o` rises after 31 more bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| bank_a_i | input | BANK_W | Outputs of oscillator bank A, asynchronous to the clock |
| bank_b_i | input | BANK_W | Outputs of oscillator bank B, asynchronous to the clock |
| rd_strobe_i | input | 1 | One-cycle pulse marking a read of the word |
| word_o | output | WORD_W | The most recent conditioned bits, newest at bit 0 |
| ready_o | output | 1 | A full fresh word has arrived since the last read |

## Verification
The two functions that can fall on the same clock edge are a software read, which clears the ready flag and the fresh count, and the arrival of a conditioned bit, which advances that count. The bench counts clock cycles from reset release. This lets it place the read strobe exactly on the edge where the 32nd fresh bit is shifted in: two cycles after the sample edge that closes a pair. It judges the outcome at the ports. The ready flag must stay low at that point, must still be low after 30 more bits, and must rise after the 31st. A late read would need 32 more bits, and a read that loses to the bit would leave the flag high.

// File: rtl/ewc_pkg.sv
// Shared constants and types for the entropy word collector.
// Assumes exactly two oscillator banks feed the block.
package ewc_pkg;
    parameter int unsigned NUM_BANKS       = 2;
    parameter int unsigned SAMPLES_PER_BIT = 2;
    parameter int unsigned SYNC_STAGES     = 2;

    typedef logic [NUM_BANKS-1:0] bank_bits_t;
endpackage

// File: rtl/ewc_interval_timer.sv
// Free-running sample interval timer.
// Raises capture_o for one cycle out of every INTERVAL cycles. captured_o is
// the same pulse one cycle later, marking when the latched samples are valid.
// Assumes INTERVAL >= 2.
module ewc_interval_timer #(
    parameter int unsigned INTERVAL = 4096
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic capture_o,
    output logic captured_o
);
    localparam int unsigned CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             captured_q;

    // Sample edge whenever the counter sits at its last value.
    assign capture_o  = (cnt_q == LAST);
    assign captured_o = captured_q;

    // Count cycles and wrap at the end of each interval.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q      <= '0;
            captured_q <= 1'b0;
        end else begin
            cnt_q      <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            captured_q <= capture_o;
        end
    end
endmodule

// File: rtl/ewc_bank_sampler.sv
// Synchronizes one oscillator bank, folds it to a parity bit and latches that
// bit on the sample edge. Assumes the inputs are fully asynchronous.
module ewc_bank_sampler #(
    parameter int unsigned BANK_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [BANK_W-1:0] osc_i,
    input  logic              take_i,
    output logic              sample_o
);
    logic [BANK_W-1:0] sync_q [SYNC_STAGES];
    logic              fold;
    logic              sample_q;

    // Move every oscillator line through the synchronizer chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
        end else begin
            sync_q[0] <= osc_i;
            for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
        end
    end

    // Parity of the synchronized bank.
    assign fold = ^sync_q[SYNC_STAGES-1];

    // Latch the parity bit only at the sample edge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     sample_q <= 1'b0;
        else if (take_i) sample_q <= fold;
    end

    assign sample_o = sample_q;
endmodule

// File: rtl/ewc_conditioner.sv
// Combines SAMPLES_PER_BIT consecutive samples of every bank into one bit by
// XOR. Emits bit_o with a one-cycle valid_o when a group of samples is
// complete. Assumes sample_valid_i pulses once per sample interval.
module ewc_conditioner #(
    parameter int unsigned NUM_BANKS       = 2,
    parameter int unsigned SAMPLES_PER_BIT = 2
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 sample_valid_i,
    input  logic [NUM_BANKS-1:0] samples_i,
    output logic                 bit_o,
    output logic                 valid_o
);
    localparam int unsigned PH_W = (SAMPLES_PER_BIT > 1) ? $clog2(SAMPLES_PER_BIT) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(SAMPLES_PER_BIT - 1);

    logic [PH_W-1:0] phase_q;
    logic            acc_q;
    logic            bit_q;
    logic            valid_q;
    logic            mix;

    // XOR across banks, folded into the running value of this group.
    assign mix = acc_q ^ (^samples_i);

    // Step through the group and release the bit once it is complete.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= '0;
            acc_q   <= 1'b0;
            bit_q   <= 1'b0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (sample_valid_i) begin
                if (phase_q == PH_LAST) begin
                    bit_q   <= mix;
                    valid_q <= 1'b1;
                    acc_q   <= 1'b0;
                    phase_q <= '0;
                end else begin
                    acc_q   <= mix;
                    phase_q <= phase_q + 1'b1;
                end
            end
        end
    end

    assign bit_o   = bit_q;
    assign valid_o = valid_q;
endmodule

// File: rtl/ewc_word_accum.sv
// Shifts conditioned bits into the word (newest at bit 0). Counts fresh bits
// since the last read and raises ready when a whole word is fresh. A read on
// the same edge as a bit takes priority, and that bit counts as fresh.
module ewc_word_accum #(
    parameter int unsigned WORD_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bit_i,
    input  logic              bit_valid_i,
    input  logic              rd_i,
    output logic [WORD_W-1:0] word_o,
    output logic              ready_o
);
    localparam int unsigned FRESH_W = $clog2(WORD_W);
    localparam logic [FRESH_W-1:0] FRESH_LAST = FRESH_W'(WORD_W - 1);

    logic [WORD_W-1:0]  word_q;
    logic [FRESH_W-1:0] fresh_q;
    logic               ready_q;

    // Keep shifting new bits in whether or not the word has been read.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)          word_q <= '0;
        else if (bit_valid_i) word_q <= {word_q[WORD_W-2:0], bit_i};
    end

    // Track fresh bits since the last read and drive the ready flag.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fresh_q <= '0;
            ready_q <= 1'b0;
        end else if (rd_i) begin
            ready_q <= 1'b0;
            fresh_q <= bit_valid_i ? FRESH_W'(1) : '0;
        end else if (bit_valid_i) begin
            if (fresh_q == FRESH_LAST) begin
                ready_q <= 1'b1;
                fresh_q <= '0;
            end else begin
                fresh_q <= fresh_q + 1'b1;
            end
        end
    end

    assign word_o  = word_q;
    assign ready_o = ready_q;
endmodule

// File: rtl/entropy_word_collector.sv
// Top of the entropy word collector: an interval timer, one sampler per bank,
// a space-time XOR conditioner and the word accumulator.
// Assumes bank inputs are asynchronous and the read strobe is one cycle wide.
module entropy_word_collector
    import ewc_pkg::*;
#(
    parameter int unsigned BANK_W          = 16,
    parameter int unsigned SAMPLE_INTERVAL = 4096,
    parameter int unsigned WORD_W          = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [BANK_W-1:0] bank_a_i,
    input  logic [BANK_W-1:0] bank_b_i,
    input  logic              rd_strobe_i,
    output logic [WORD_W-1:0] word_o,
    output logic              ready_o
);
    logic              capture;
    logic              captured;
    logic [BANK_W-1:0] osc_bus [NUM_BANKS];
    bank_bits_t        bank_bits;
    logic              cond_bit;
    logic              cond_valid;

    // Gather the bank inputs into one array for the sampler loop.
    assign osc_bus[0] = bank_a_i;
    assign osc_bus[1] = bank_b_i;

    ewc_interval_timer #(.INTERVAL(SAMPLE_INTERVAL)) timer_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .capture_o  (capture),
        .captured_o (captured)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        ewc_bank_sampler #(.BANK_W(BANK_W), .SYNC_STAGES(SYNC_STAGES)) sampler_i (
            .clk_i    (clk_i),
            .rst_ni   (rst_ni),
            .osc_i    (osc_bus[g]),
            .take_i   (capture),
            .sample_o (bank_bits[g])
        );
    end

    ewc_conditioner #(.NUM_BANKS(NUM_BANKS), .SAMPLES_PER_BIT(SAMPLES_PER_BIT)) cond_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .sample_valid_i (captured),
        .samples_i      (bank_bits),
        .bit_o          (cond_bit),
        .valid_o        (cond_valid)
    );

    ewc_word_accum #(.WORD_W(WORD_W)) accum_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .bit_i       (cond_bit),
        .bit_valid_i (cond_valid),
        .rd_i        (rd_strobe_i),
        .word_o      (word_o),
        .ready_o     (ready_o)
    );
endmodule

// File: rtl/ewc_checker.sv
// Property checker for the entropy word collector, bound to the top module.
// Observes the ports plus the sample pulse and the conditioned-bit valid.
module ewc_checker #(
    parameter int unsigned WORD_W = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              rd_strobe_i,
    input logic [WORD_W-1:0] word_o,
    input logic              ready_o,
    input logic              capture_i,
    input logic              bit_valid_i
);
    // A reset edge leaves an empty word and a low flag.
    assert_reset_state_R1: assert property (@(posedge clk_i)
        !rst_ni |=> (word_o == '0 && !ready_o));

    // Sample edges are single-cycle pulses.
    assert_capture_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        capture_i |=> !capture_i);

    // The word moves only on the edge after a conditioned bit.
    assert_word_moves_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (word_o != $past(word_o)) |-> $past(bit_valid_i));

    // At most one conditioned bit per pair of samples, never back to back.
    assert_bit_pace_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_valid_i |=> !bit_valid_i);

    // A new bit pushes older bits up by one place.
    assert_shift_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_valid_i |=> (word_o[WORD_W-1:1] == $past(word_o[WORD_W-2:0])));

    // The flag can only rise when a bit arrives.
    assert_ready_rise_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ready_o) |-> $past(bit_valid_i));

    // A read always leaves the flag low, even alongside a bit (R9).
    assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_strobe_i |=> !ready_o);
endmodule

bind entropy_word_collector ewc_checker #(.WORD_W(WORD_W)) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_strobe_i (rd_strobe_i),
    .word_o      (word_o),
    .ready_o     (ready_o),
    .capture_i   (capture),
    .bit_valid_i (cond_valid)
);

// File: tb/entropy_word_collector_tb_top.sv
// Directed bench: each scenario is a task that checks its own results
// against a bench-side model of the conditioning rules.
module entropy_word_collector_tb_top;
    localparam int BANK_W   = 8;
    localparam int INTERVAL = 32;
    localparam int WORD_W   = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rd = 1'b0;
    logic [BANK_W-1:0] a = '0;
    logic [BANK_W-1:0] b = '0;
    logic [WORD_W-1:0] word;
    logic              ready;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    int smp = 0;
    int wd = 0;
    int unsigned lfsr = 32'h1234_5678;

    logic [WORD_W-1:0] m_word;
    int                m_fresh;
    logic              m_ready;
    logic              m_ph;
    logic              m_acc;

    entropy_word_collector #(.BANK_W(BANK_W), .SAMPLE_INTERVAL(INTERVAL), .WORD_W(WORD_W)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bank_a_i(a), .bank_b_i(b),
        .rd_strobe_i(rd), .word_o(word), .ready_o(ready));

    always #5 clk = ~clk;

    // Cycles since reset release, matching the interval counter.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Watchdog.
    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog (all requirements): actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
        tests = tests + 1;
        if (act !== exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_word = '0; m_fresh = 0; m_ready = 1'b0; m_ph = 1'b0; m_acc = 1'b0;
    endtask

    // Wait for the middle of the current sample window.
    task automatic goto_mid();
        while (cyc < smp * INTERVAL + INTERVAL / 2) @(negedge clk);
    endtask

    // Drive one sample value; collide places a read on the edge of the new bit.
    task automatic drive(input logic [BANK_W-1:0] av, input logic [BANK_W-1:0] bv, input bit collide);
        logic p;
        a = av; b = bv;
        p = (^av) ^ (^bv);
        smp = smp + 1;
        if (!m_ph) begin
            m_acc = p; m_ph = 1'b1;
        end else begin
            m_word = {m_word[WORD_W-2:0], m_acc ^ p};
            m_ph = 1'b0;
            if (collide) begin
                m_fresh = 1; m_ready = 1'b0;
                while (cyc < smp * INTERVAL + 1) @(negedge clk);
                rd = 1'b1;
                @(negedge clk);
                rd = 1'b0;
            end else if (m_fresh == WORD_W - 1) begin
                m_fresh = 0; m_ready = 1'b1;
            end else begin
                m_fresh = m_fresh + 1;
            end
        end
    endtask

    function automatic logic [BANK_W-1:0] rnd();
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        return lfsr[BANK_W+3:4];
    endfunction

    // Produce n random bits; glitch adds short pulses between sample edges.
    task automatic run_bits(input int n, input bit glitch);
        for (int i = 0; i < n; i++) begin
            for (int k = 0; k < 2; k++) begin
                goto_mid();
                drive(rnd(), rnd(), 1'b0);
                if (glitch) begin
                    repeat (4) @(negedge clk);
                    a = ~a; b = b ^ 8'h01;
                    repeat (3) @(negedge clk);
                    a = ~a; b = b ^ 8'h01;
                end
            end
        end
        goto_mid();
    endtask

    task automatic do_read();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        m_fresh = 0; m_ready = 1'b0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        a = '0; b = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        smp = 0;
        model_reset();
    endtask

    // R1: state after reset.
    task automatic test_reset();
        apply_reset();
        chk("R1 word after reset", word, '0);
        chk("R1 ready after reset", {31'b0, ready}, 32'd0);
    endtask

    // R3, R4, R5: directed parity patterns and bit order.
    task automatic test_directed();
        goto_mid(); drive(8'h07, 8'h00, 1'b0);
        goto_mid(); drive(8'h00, 8'h00, 1'b0);
        goto_mid(); chk("R3 odd bank A parity", word, 32'h1);
        drive(8'h03, 8'h81, 1'b0);
        goto_mid(); drive(8'hFF, 8'h11, 1'b0);
        goto_mid(); chk("R3 even parities", word, 32'h2);
        drive(8'h00, 8'h01, 1'b0);
        goto_mid(); drive(8'h00, 8'h00, 1'b0);
        goto_mid(); chk("R4 bank B contributes", word, 32'h5);
        drive(8'h01, 8'h00, 1'b0);
        goto_mid(); drive(8'h01, 8'h01, 1'b0);
        goto_mid();
        chk("R5 newest bit at bit 0", word, 32'hB);
        chk("R4 model after directed", word, m_word);
    endtask

    // R4, R6: fill to 31 then 32 bits.
    task automatic test_fill();
        run_bits(27, 1'b0);
        chk("R4 word after 31 bits", word, m_word);
        chk("R6 ready low at 31 bits", {31'b0, ready}, 32'd0);
        run_bits(1, 1'b0);
        chk("R6 ready high at 32 bits", {31'b0, ready}, 32'd1);
        chk("R4 word after 32 bits", word, m_word);
    endtask

    // R7: unread word keeps absorbing bits.
    task automatic test_overwrite();
        run_bits(10, 1'b0);
        chk("R7 word holds latest bits", word, m_word);
        chk("R7 ready stays high", {31'b0, ready}, 32'd1);
    endtask

    // R8: read clears the flag until 32 new bits.
    task automatic test_read();
        do_read();
        chk("R8 ready cleared by read", {31'b0, ready}, 32'd0);
        run_bits(31, 1'b0);
        chk("R8 ready low after 31 new bits", {31'b0, ready}, 32'd0);
        run_bits(1, 1'b0);
        chk("R8 ready high after 32 new bits", {31'b0, ready}, 32'd1);
        chk("R8 word intact", word, m_word);
    endtask

    // R2: pulses between sample edges leave no trace.
    task automatic test_glitch();
        run_bits(4, 1'b1);
        chk("R2 glitches ignored", word, m_word);
    endtask

    // R9: read and 32nd fresh bit on the same edge.
    task automatic test_collision();
        do_read();
        run_bits(31, 1'b0);
        chk("R9 ready low before collision", {31'b0, ready}, 32'd0);
        drive(rnd(), rnd(), 1'b0);
        goto_mid();
        drive(rnd(), rnd(), 1'b1);
        goto_mid();
        chk("R9 read wins on collision", {31'b0, ready}, 32'd0);
        chk("R9 colliding bit still shifted", word, m_word);
        run_bits(30, 1'b0);
        chk("R9 ready low after 30 more", {31'b0, ready}, 32'd0);
        run_bits(1, 1'b0);
        chk("R9 ready high after 31 more", {31'b0, ready}, 32'd1);
    endtask

    // R1: reset during operation restarts everything.
    task automatic test_reset_mid();
        apply_reset();
        chk("R1 word cleared mid-run", word, '0);
        chk("R1 ready cleared mid-run", {31'b0, ready}, 32'd0);
        run_bits(3, 1'b0);
        chk("R1 pairing restarts after reset", word, m_word);
    endtask

    initial begin
        model_reset();
        test_reset();
        test_directed();
        test_fill();
        test_overwrite();
        test_read();
        test_glitch();
        test_collision();
        test_reset_mid();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule